// File: doc/BRIEF.md
# External interrupt pin controller

This block turns one external interrupt request pin into a sticky status flag and a maskable interrupt request. The raw pin goes through a synchroniser. A polarity bit chooses whether high or low counts as asserted, and the controller detects transitions into the asserted level. A mode bit adds level holding: once a transition has set the flag, the flag cannot be cleared while the pin stays asserted.

Software controls the block through one control/status register on a simple write strobe and data bus. The register holds the interrupt enable, the mode, a write-only acknowledge, the read-only flag, the pin enable, the pull-device disable and the polarity. The block also drives the pad's pull-enable and pull-direction controls. Enabling the pin while it is already asserted raises a spurious flag. The intended start-up order is to enable the pin, acknowledge, and only then set the interrupt enable.

Top module: `extirq_ctrl`

## Requirements
- R1: After reset, `irq_flag`, `irq_req`, `pull_en` and `bus_rdata` are all 0, and `pull_up` is 1 (the polarity bit resets to 0, which selects active-low).
- R2: Register bit 6 selects the polarity: 1 means high is asserted and 0 means low is asserted. With the pin enabled, a transition of the synchronised pin from the deasserted to the asserted level sets `irq_flag` on the third clock edge after the pin changes. In edge mode (bit 1 = 0), the flag then stays set after the pin returns to the deasserted level.
- R3: With bit 1 = 1 (level mode), a flag set by a transition stays set while the pin remains asserted, and writing the acknowledge bit has no effect during that time.
- R4: Writing a 1 to bit 2 (acknowledge) clears `irq_flag` on that clock edge. This applies in edge mode even while the pin is asserted, and in level mode once the pin is deasserted. Bit 2 always reads as 0.
- R5: If a transition into the asserted level and an acknowledge write occur in the same cycle, the flag ends up set.
- R6: `irq_req` equals `irq_flag` AND the interrupt enable (bit 0). Clearing bit 0 drops `irq_req` and leaves `irq_flag` unchanged.
- R7: While the pin enable (bit 4) is 0, `irq_flag` is held at 0 and pin transitions are ignored. Setting bit 4 while the pin is already at the asserted level sets the flag.
- R8: `pull_en` = bit 4 AND NOT bit 5 (pull-device disable). `pull_up` = NOT bit 6, so an active-low pin is pulled up and an active-high pin is pulled down. Both follow a write on the next clock edge.
- R9: `bus_rdata` is registered and shows the register state of the previous cycle: bit 0 enable, bit 1 mode, bit 3 flag, bit 4 pin enable, bit 5 pull disable, bit 6 polarity. Bits 2 and 7 read as 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_raw | input | 1 | Asynchronous external interrupt pin level |
| bus_wr | input | 1 | Register write strobe |
| bus_wdata | input | DW | Register write data |
| bus_rdata | output | DW | Registered register readback |
| irq_flag | output | 1 | Sticky interrupt status flag |
| irq_req | output | 1 | Interrupt request (flag AND enable) |
| pull_en | output | 1 | Pad pull-device enable |
| pull_up | output | 1 | Pad pull direction, 1 = up, 0 = down |

## Verification
The hardest case to reach is a transition and an acknowledge landing in the same cycle. The transition is only seen three clock edges after the pin moves. The bench raises the pin and then issues the acknowledge write exactly two cycles later, so that both reach the flag on the same edge.

Two other cases need deliberate sequences. The first is a polarity change made while the pin sits at the newly asserted level. The second is enabling the pin while it is already asserted. For both, the bench drives the pin before the register write and checks that the flag rises.

// File: rtl/extirq_pkg.sv
package extirq_pkg;

  // Bit positions inside the control/status register
  localparam int BIT_IE   = 0;
  localparam int BIT_LVL  = 1;
  localparam int BIT_ACK  = 2;
  localparam int BIT_FLAG = 3;
  localparam int BIT_PEN  = 4;
  localparam int BIT_PDIS = 5;
  localparam int BIT_POL  = 6;

  typedef struct packed {
    logic pol_hi;    // 1: high is asserted
    logic pull_dis;  // 1: internal pull device off
    logic pin_en;    // 1: pin sampled
    logic mode_lvl;  // 1: edge plus level hold
    logic int_en;    // 1: request unmasked
  } ctrl_t;

  localparam ctrl_t CTRL_RESET = '0;

endpackage

// File: rtl/extirq_sync.sv
module extirq_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);

  logic [STAGES-1:0] chain;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) chain[0] <= 1'b0;
        else     chain[0] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) chain[i] <= 1'b0;
        else     chain[i] <= chain[i-1];
      end
    end
  end

  assign q = chain[STAGES-1];

endmodule

// File: rtl/extirq_regs.sv
module extirq_regs
  import extirq_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          bus_wr,
  input  logic [DW-1:0] bus_wdata,
  input  logic          flag_q,
  output ctrl_t         ctrl_q,
  output ctrl_t         ctrl_d,
  output logic          ack_pulse,
  output logic [DW-1:0] bus_rdata
);

  logic [DW-1:0] rd_d;
  logic          unused_wbits;

  // Reserved and read-only bits of the write data are dropped
  assign unused_wbits = ^{bus_wdata[DW-1:BIT_POL+1], bus_wdata[BIT_FLAG]};

  always_comb begin
    ctrl_d = ctrl_q;
    if (bus_wr) begin
      ctrl_d.int_en   = bus_wdata[BIT_IE];
      ctrl_d.mode_lvl = bus_wdata[BIT_LVL];
      ctrl_d.pin_en   = bus_wdata[BIT_PEN];
      ctrl_d.pull_dis = bus_wdata[BIT_PDIS];
      ctrl_d.pol_hi   = bus_wdata[BIT_POL];
    end
  end

  assign ack_pulse = bus_wr & bus_wdata[BIT_ACK];

  always_comb begin
    rd_d           = '0;
    rd_d[BIT_IE]   = ctrl_q.int_en;
    rd_d[BIT_LVL]  = ctrl_q.mode_lvl;
    rd_d[BIT_FLAG] = flag_q;
    rd_d[BIT_PEN]  = ctrl_q.pin_en;
    rd_d[BIT_PDIS] = ctrl_q.pull_dis;
    rd_d[BIT_POL]  = ctrl_q.pol_hi;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q    <= CTRL_RESET;
      bus_rdata <= '0;
    end else begin
      ctrl_q    <= ctrl_d;
      bus_rdata <= rd_d;
    end
  end

endmodule

// File: rtl/extirq_detect.sv
module extirq_detect
  import extirq_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  pin_sync,
  input  ctrl_t ctrl_q,
  input  logic  ack_pulse,
  output logic  pin_act,
  output logic  edge_hit,
  output logic  flag_d,
  output logic  flag_q
);

  logic prev_act;

  // Asserted-ness of the current sample under the selected polarity
  assign pin_act  = ctrl_q.pol_hi ? pin_sync : ~pin_sync;
  assign edge_hit = ctrl_q.pin_en & pin_act & ~prev_act;

  always_comb begin
    if (!ctrl_q.pin_en)
      flag_d = 1'b0;
    else if (edge_hit)
      flag_d = 1'b1;                       // set beats acknowledge
    else if (ack_pulse && !(ctrl_q.mode_lvl && pin_act))
      flag_d = 1'b0;
    else
      flag_d = flag_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_act <= 1'b0;
      flag_q   <= 1'b0;
    end else begin
      // Disabled pin forgets its history, so enabling at the asserted level flags
      prev_act <= ctrl_q.pin_en & pin_act;
      flag_q   <= flag_d;
    end
  end

endmodule

// File: rtl/extirq_ctrl.sv
module extirq_ctrl
  import extirq_pkg::*;
#(
  parameter int DW          = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          pin_raw,
  input  logic          bus_wr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  output logic          irq_flag,
  output logic          irq_req,
  output logic          pull_en,
  output logic          pull_up
);

  ctrl_t ctrl_q;
  ctrl_t ctrl_d;
  logic  pin_sync;
  logic  ack_pulse;
  logic  pin_act;
  logic  edge_hit;
  logic  flag_d;
  logic  ie_q;
  logic  mode_q;
  logic  pen_q;

  extirq_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (pin_raw),
    .q   (pin_sync)
  );

  extirq_regs #(.DW(DW)) u_regs (
    .clk       (clk),
    .rst       (rst),
    .bus_wr    (bus_wr),
    .bus_wdata (bus_wdata),
    .flag_q    (irq_flag),
    .ctrl_q    (ctrl_q),
    .ctrl_d    (ctrl_d),
    .ack_pulse (ack_pulse),
    .bus_rdata (bus_rdata)
  );

  extirq_detect u_det (
    .clk       (clk),
    .rst       (rst),
    .pin_sync  (pin_sync),
    .ctrl_q    (ctrl_q),
    .ack_pulse (ack_pulse),
    .pin_act   (pin_act),
    .edge_hit  (edge_hit),
    .flag_d    (flag_d),
    .flag_q    (irq_flag)
  );

  assign ie_q   = ctrl_q.int_en;
  assign mode_q = ctrl_q.mode_lvl;
  assign pen_q  = ctrl_q.pin_en;

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_req <= 1'b0;
      pull_en <= 1'b0;
      pull_up <= 1'b1;
    end else begin
      irq_req <= flag_d & ctrl_d.int_en;
      pull_en <= ctrl_d.pin_en & ~ctrl_d.pull_dis;
      pull_up <= ~ctrl_d.pol_hi;
    end
  end

endmodule

// File: rtl/extirq_ctrl_chk.sv
module extirq_ctrl_chk
  import extirq_pkg::*;
#(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst,
  input logic          irq_flag,
  input logic          irq_req,
  input logic [DW-1:0] bus_rdata,
  input logic          ie_q,
  input logic          mode_q,
  input logic          pen_q,
  input logic          act,
  input logic          edge_hit,
  input logic          ack
);

  a_r2_rise_needs_edge: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_flag) |-> $past(edge_hit));

  a_r3_level_hold: assert property (@(posedge clk) disable iff (rst)
    (pen_q && mode_q && act && irq_flag) |=> irq_flag);

  a_r4_ack_clears: assert property (@(posedge clk) disable iff (rst)
    (ack && pen_q && !edge_hit && !(mode_q && act)) |=> !irq_flag);

  a_r4_ack_reads_zero: assert property (@(posedge clk) disable iff (rst)
    !bus_rdata[BIT_ACK]);

  a_r5_edge_wins: assert property (@(posedge clk) disable iff (rst)
    edge_hit |=> irq_flag);

  a_r6_req_masked: assert property (@(posedge clk) disable iff (rst)
    irq_req == (irq_flag & ie_q));

  a_r7_disabled_clear: assert property (@(posedge clk) disable iff (rst)
    !pen_q |=> !irq_flag);

endmodule

bind extirq_ctrl extirq_ctrl_chk #(.DW(DW)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .irq_flag  (irq_flag),
  .irq_req   (irq_req),
  .bus_rdata (bus_rdata),
  .ie_q      (ie_q),
  .mode_q    (mode_q),
  .pen_q     (pen_q),
  .act       (pin_act),
  .edge_hit  (edge_hit),
  .ack       (ack_pulse)
);

// File: tb/extirq_ctrl_tb.sv
`timescale 1ns/1ps
module extirq_ctrl_tb;

  localparam int DW = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          pin_raw = 1'b1;
  logic          bus_wr = 1'b0;
  logic [DW-1:0] bus_wdata = '0;
  logic [DW-1:0] bus_rdata;
  logic          irq_flag, irq_req, pull_en, pull_up;

  int n_cmp = 0;
  int n_bad = 0;
  int cyc   = 0;
  bit armed = 0;
  bit done  = 0;

  always #4 clk = ~clk;   // 125 MHz

  extirq_ctrl #(.DW(DW)) u_dut (
    .clk(clk), .rst(rst), .pin_raw(pin_raw), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_flag(irq_flag),
    .irq_req(irq_req), .pull_en(pull_en), .pull_up(pull_up)
  );

  // Behavioural reference model
  bit m_s1, m_s2, m_pact, m_flag, m_irq, m_pen_o, m_pup;
  bit m_ie, m_lvl, m_pen, m_pdis, m_pol;
  bit [7:0] m_rd;

  always @(posedge clk) begin
    bit act, edg, ack, fn;
    bit [7:0] rn;
    if (rst) begin
      m_s1 = 0; m_s2 = 0; m_pact = 0; m_flag = 0; m_irq = 0;
      m_pen_o = 0; m_pup = 1; m_rd = 0;
      m_ie = 0; m_lvl = 0; m_pen = 0; m_pdis = 0; m_pol = 0;
    end else begin
      rn  = {1'b0, m_pol, m_pdis, m_pen, m_flag, 1'b0, m_lvl, m_ie};
      act = m_pol ? m_s2 : !m_s2;
      edg = m_pen && act && !m_pact;
      ack = bus_wr && bus_wdata[2];
      if (!m_pen) fn = 0;
      else if (edg) fn = 1;
      else if (ack && !(m_lvl && act)) fn = 0;
      else fn = m_flag;
      m_pact = m_pen && act;
      m_s2 = m_s1;
      m_s1 = pin_raw;
      if (bus_wr) begin
        m_ie = bus_wdata[0]; m_lvl = bus_wdata[1]; m_pen = bus_wdata[4];
        m_pdis = bus_wdata[5]; m_pol = bus_wdata[6];
      end
      m_flag = fn;
      m_irq = fn && m_ie;
      m_pen_o = m_pen && !m_pdis;
      m_pup = !m_pol;
      m_rd = rn;
    end
  end

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  // Per-cycle comparison against the model
  always @(negedge clk) begin
    if (armed && !done) begin
      chk("R2 flag vs model", {7'd0, irq_flag}, {7'd0, m_flag});
      chk("R6 irq_req vs model", {7'd0, irq_req}, {7'd0, m_irq});
      chk("R8 pull_en vs model", {7'd0, pull_en}, {7'd0, m_pen_o});
      chk("R8 pull_up vs model", {7'd0, pull_up}, {7'd0, m_pup});
      chk("R9 rdata vs model", bus_rdata, m_rd);
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000 && !done) begin
      done = 1;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] v);
    bus_wr = 1'b1; bus_wdata = v;
    @(negedge clk);
    bus_wr = 1'b0; bus_wdata = '0;
  endtask

  initial begin
    idle(4);
    rst = 1'b0;
    armed = 1;
    idle(1);
    // R1 reset state
    chk("R1 flag", {7'd0, irq_flag}, 8'd0);
    chk("R1 irq_req", {7'd0, irq_req}, 8'd0);
    chk("R1 rdata", bus_rdata, 8'h00);
    chk("R1 pull_en", {7'd0, pull_en}, 8'd0);
    chk("R1 pull_up", {7'd0, pull_up}, 8'd1);

    // enable pin, high polarity, pin deasserted: no flag
    pin_raw = 1'b0;
    wr(8'h50); idle(4);
    wr(8'h54); idle(2);
    chk("R7 no flag when enabled deasserted", {7'd0, irq_flag}, 8'd0);
    wr(8'h51);

    // rising transition sets a sticky flag
    pin_raw = 1'b1; idle(4);
    chk("R2 rising sets flag", {7'd0, irq_flag}, 8'd1);
    chk("R6 request follows flag", {7'd0, irq_req}, 8'd1);
    pin_raw = 1'b0; idle(4);
    chk("R2 flag sticky in edge mode", {7'd0, irq_flag}, 8'd1);
    wr(8'h55); idle(2);
    chk("R4 ack clears", {7'd0, irq_flag}, 8'd0);

    // transition and acknowledge in the same cycle
    pin_raw = 1'b1;
    @(negedge clk); @(negedge clk);
    bus_wr = 1'b1; bus_wdata = 8'h55;
    @(negedge clk);
    bus_wr = 1'b0; bus_wdata = '0;
    chk("R5 set wins over ack", {7'd0, irq_flag}, 8'd1);

    // masking
    pin_raw = 1'b0; idle(4);
    pin_raw = 1'b1; idle(4);
    wr(8'h50); idle(1);
    chk("R6 masked request", {7'd0, irq_req}, 8'd0);
    chk("R6 flag kept when masked", {7'd0, irq_flag}, 8'd1);
    wr(8'h51); idle(1);
    chk("R6 unmasked request", {7'd0, irq_req}, 8'd1);
    wr(8'h55); idle(1);
    chk("R4 ack clears edge mode pin asserted", {7'd0, irq_flag}, 8'd0);

    // level mode
    wr(8'h53); idle(2);
    chk("R9 readback", bus_rdata & 8'hF7, 8'h53);
    pin_raw = 1'b0; idle(4);
    pin_raw = 1'b1; idle(4);
    chk("R3 level mode flag set", {7'd0, irq_flag}, 8'd1);
    wr(8'h57); idle(1);
    chk("R3 ack ignored while asserted", {7'd0, irq_flag}, 8'd1);
    chk("R4 ack bit reads zero", {7'd0, bus_rdata[2]}, 8'd0);
    pin_raw = 1'b0; idle(4);
    chk("R3 flag kept after deassert", {7'd0, irq_flag}, 8'd1);
    wr(8'h57); idle(1);
    chk("R4 ack clears once deasserted", {7'd0, irq_flag}, 8'd0);

    // low polarity; switching while pin low raises a flag
    wr(8'h11); idle(4);
    chk("R2 polarity switch flags", {7'd0, irq_flag}, 8'd1);
    wr(8'h15); idle(1);
    pin_raw = 1'b1; idle(4);
    chk("R2 rising ignored in low polarity", {7'd0, irq_flag}, 8'd0);
    pin_raw = 1'b0; idle(4);
    chk("R2 falling sets flag low polarity", {7'd0, irq_flag}, 8'd1);
    wr(8'h15); idle(1);

    // pin enable
    pin_raw = 1'b1; idle(4);
    pin_raw = 1'b0; idle(4);
    wr(8'h01); idle(2);
    chk("R7 disable clears flag", {7'd0, irq_flag}, 8'd0);
    pin_raw = 1'b1; idle(4);
    pin_raw = 1'b0; idle(4);
    chk("R7 disabled pin ignored", {7'd0, irq_flag}, 8'd0);
    wr(8'h11); idle(3);
    chk("R7 enable while asserted flags", {7'd0, irq_flag}, 8'd1);

    // pull control
    wr(8'h31); idle(1);
    chk("R8 pull disabled", {7'd0, pull_en}, 8'd0);
    wr(8'h11); idle(1);
    chk("R8 pull enabled", {7'd0, pull_en}, 8'd1);
    chk("R8 pull up for low polarity", {7'd0, pull_up}, 8'd1);
    wr(8'h51); idle(1);
    chk("R8 pull down for high polarity", {7'd0, pull_up}, 8'd0);
    wr(8'h21); idle(1);
    chk("R8 pull off with pin disabled", {7'd0, pull_en}, 8'd0);
    idle(3);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule